// File: doc/BRIEF.md
# Coarse Frequency Acquisition Loop with Dead Zone

This block brings an oscillator to roughly the right frequency before a finer phase loop takes over. On every reference clock cycle it samples a tick input derived from the oscillator. It counts the ticks seen across a fixed measurement window of reference cycles. At the end of each window it compares that count with a target word. It then moves an 8-bit coarse tuning code, which drives a capacitor bank, one step up or down.

When the signed error (target minus count) lies inside a programmable dead band, the code is frozen. This means the coarse loop cannot fight the phase loop once the frequency is close. After a programmable number of consecutive windows inside the band, a lock flag is raised, and that flag enables the phase path. The flag is dropped only after two consecutive windows outside the band.

Top module: `coarse_freq_loop`

## Requirements
- R1: While reset is low, and after it is released, `coarse_code` is 128 and `freq_locked` is 0.
- R2: A window is `WIN_LEN` reference cycles long, with the first cycle after reset release as its first cycle. `coarse_code` and `freq_locked` change only on the clock edge that closes a window.
- R3: The window count is the number of cycles in that window with `tick` high. If `target - count` is greater than `dz_bound`, the code rises by 1.
- R4: If `target - count` is less than `-dz_bound`, the code falls by 1.
- R5: If `target - count` lies in the range from `-dz_bound` to `+dz_bound` inclusive, the code is held.
- R6: The code saturates. It stays at 255 on an up step and at 0 on a down step.
- R7: `freq_locked` rises at the end of the window that completes `lock_need` consecutive in-band windows. A `lock_need` of 0 acts as 1.
- R8: One out-of-band window does not clear `freq_locked`, but it restarts the in-band run. Two consecutive out-of-band windows clear it.
- R9: The tick count restarts from zero in every window, and nothing is carried from the previous window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oscillator-derived count enable, sampled each cycle |
| target | input | 12 | Frequency control word: expected ticks per window |
| dz_bound | input | 12 | Half-width of the dead band |
| lock_need | input | 4 | In-band windows required for lock |
| coarse_code | output | 8 | Coarse capacitor-bank code |
| freq_locked | output | 1 | Frequency lock flag |

## Verification
Both results are registered on the edge that closes a window, so they are due exactly `WIN_LEN` cycles after that window's first tick is driven. The bench drives and samples on falling edges. It checks both outputs on the falling edge just after each window closes. It also confirms on every falling edge inside a window that they still hold their last values. The sweep walks the tick count over every value from 0 to the full window, under several targets, dead-band widths and lock lengths. It also takes the code to both rails.

// File: rtl/coarse_freq_loop.sv
module coarse_freq_loop #(
  parameter int CNT_W   = 12,
  parameter int CODE_W  = 8,
  parameter int RUN_W   = 4,
  parameter int WIN_LEN = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  target,
  input  logic [CNT_W-1:0]  dz_bound,
  input  logic [RUN_W-1:0]  lock_need,
  output logic [CODE_W-1:0] coarse_code,
  output logic              freq_locked
);
  localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [WIN_W-1:0]  WIN_LAST = WIN_W'(WIN_LEN - 1);
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [WIN_W-1:0] win_cnt;
  logic [CNT_W-1:0] edge_cnt, total;
  logic [RUN_W-1:0] in_run, in_next, need;
  logic             out_pend, win_end, step_up, step_dn, in_band;
  logic signed [CNT_W:0] err, dz;

  assign win_end = (win_cnt == WIN_LAST);
  assign total   = (tick && edge_cnt != '1) ? edge_cnt + CNT_W'(1) : edge_cnt;
  assign err     = $signed({1'b0, target}) - $signed({1'b0, total});
  assign dz      = $signed({1'b0, dz_bound});
  assign step_up = err > dz;
  assign step_dn = err < -dz;
  assign in_band = !step_up && !step_dn;
  assign need    = (lock_need == '0) ? RUN_W'(1) : lock_need;
  assign in_next = (in_run == '1) ? in_run : in_run + RUN_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
    end else if (win_end) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
    end else begin
      win_cnt  <= win_cnt + WIN_W'(1);
      edge_cnt <= total;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coarse_code <= CODE_MID;
    end else if (win_end) begin
      if (step_up && coarse_code != CODE_MAX)
        coarse_code <= coarse_code + CODE_W'(1);
      else if (step_dn && coarse_code != '0)
        coarse_code <= coarse_code - CODE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_run      <= '0;
      out_pend    <= 1'b0;
      freq_locked <= 1'b0;
    end else if (win_end) begin
      if (in_band) begin
        in_run   <= in_next;
        out_pend <= 1'b0;
        if (in_next >= need) freq_locked <= 1'b1;
      end else begin
        in_run   <= '0;
        out_pend <= 1'b1;
        if (out_pend) freq_locked <= 1'b0;
      end
    end
  end

  AST_MIDWIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(coarse_code) && $stable(freq_locked)); // R2
  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (coarse_code - $past(coarse_code) == CODE_W'(1)) ||
                ($past(coarse_code) - coarse_code == CODE_W'(1)) ||
                $stable(coarse_code)); // R3
  AST_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    win_end && in_band |=> $stable(coarse_code)); // R5
  AST_TOP_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_code == CODE_MAX && step_up |=> coarse_code == CODE_MAX); // R6
  AST_BOTTOM_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_code == '0 && step_dn |=> coarse_code == '0); // R6
  AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freq_locked) |-> $past(in_band)); // R7
  AST_LOCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(freq_locked) |-> $past(out_pend) && !$past(in_band)); // R8
endmodule

// File: tb/coarse_freq_loop_test.sv
module coarse_freq_loop_test;
  localparam int WL = 16;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [11:0] target = 12'd0, dz_bound = 12'd0;
  logic [3:0]  lock_need = 4'd1;
  logic [7:0]  coarse_code;
  logic        freq_locked;
  int checks = 0, errors = 0;
  int m_code = 128, m_in = 0;
  bit m_lock = 0, m_pend = 0, done = 0;

  coarse_freq_loop #(.WIN_LEN(WL)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .target(target),
    .dz_bound(dz_bound), .lock_need(lock_need),
    .coarse_code(coarse_code), .freq_locked(freq_locked));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic window(input int n);
    int err, need;
    for (int i = 0; i < WL; i++) begin
      tick = ((i * 5) % WL) < n;
      @(negedge clk);
      if (i < WL - 1) begin
        chk(coarse_code == m_code, "R2 code mid-window", coarse_code, m_code);
        chk(freq_locked == m_lock, "R2 lock mid-window", freq_locked, m_lock);
      end
    end
    err  = int'(target) - n;
    need = (lock_need == 0) ? 1 : int'(lock_need);
    if (err > int'(dz_bound)) begin
      if (m_code < 255) m_code++;
    end else if (err < -int'(dz_bound)) begin
      if (m_code > 0) m_code--;
    end
    if (err <= int'(dz_bound) && err >= -int'(dz_bound)) begin
      if (m_in < 15) m_in++;
      m_pend = 0;
      if (m_in >= need) m_lock = 1;
    end else begin
      m_in = 0;
      if (m_pend) m_lock = 0;
      m_pend = 1;
    end
    chk(coarse_code == m_code, "R3/R4/R5/R6/R9 code", coarse_code, m_code);
    chk(freq_locked == m_lock, "R7/R8 lock", freq_locked, m_lock);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(coarse_code == 128, "R1 reset code", coarse_code, 128);
    chk(freq_locked == 0, "R1 reset lock", freq_locked, 0);
    rst_n = 1'b1;
    target = 12'd10; dz_bound = 12'd2; lock_need = 4'd3;
    // R3 R4 R5 R9: sweep every tick count, several bands and lock lengths
    for (int d = 0; d < 3; d++) begin
      dz_bound = 12'(d * 2);
      for (int ln = 0; ln < 4; ln++) begin
        lock_need = 4'(ln * 2);
        for (int t = 4; t <= 14; t += 5) begin
          target = 12'(t);
          for (int n = 0; n <= WL; n++) window(n);
          for (int n = WL; n >= 0; n--) window((n * 7) % (WL + 1));
        end
      end
    end
    // R7 R8: lock run, single excursion, double excursion
    target = 12'd8; dz_bound = 12'd1; lock_need = 4'd3;
    repeat (4) window(8);
    chk(freq_locked == 1, "R7 locked after run", freq_locked, 1);
    window(0);
    chk(freq_locked == 1, "R8 single excursion keeps lock", freq_locked, 1);
    window(9); window(0); window(16);
    chk(freq_locked == 0, "R8 double excursion clears lock", freq_locked, 0);
    window(7); window(7);
    chk(freq_locked == 0, "R7 two of three in-band", freq_locked, 0);
    window(8);
    chk(freq_locked == 1, "R7 third in-band locks", freq_locked, 1);
    // R6: drive to both rails
    target = 12'd4095; dz_bound = 12'd0;
    repeat (140) window(0);
    chk(coarse_code == 255, "R6 top rail", coarse_code, 255);
    target = 12'd0;
    repeat (270) window(WL);
    chk(coarse_code == 0, "R6 bottom rail", coarse_code, 0);
    // R1: reset mid-run
    rst_n = 1'b0; tick = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(coarse_code == 128, "R1 code after re-reset", coarse_code, 128);
    chk(freq_locked == 0, "R1 lock after re-reset", freq_locked, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule